// File: doc/BRIEF.md
# Microcode address and dispatch unit

This block holds the microcode store of a microprogrammed processor and decides which word to read on each cycle. The cycle alternates between two phases, signalled by `phase`. In a phase-0 cycle the unit reads one word. The address comes from the function field of a freshly received instruction when `new_instr` is high. Otherwise it comes from the microprogram counter when `mpc_sel` is high. If neither is high, the unit stays idle.

On the following phase-1 cycle the word is split into five unit fields: program counter, microprogram counter, data memory, register file and ALU. A field is presented with its valid flag raised only when it holds a non-zero value. Fields that are all zero are suppressed.

Correct microcode never asks for both address sources in the same cycle. When that does happen, the unit raises an error flag that stays set until reset. The store is filled through a plain write port before operation.

Top module: `ucode_dispatch`

## Requirements
- R1: After reset, all five field outputs are zero, all valid flags are low, `ucode_addr` is 0 and `err` is low.
- R2: On a clock edge with `phase`=0 and `new_instr`=1, `ucode_addr` takes the value of `func`, and that word of the store is read.
- R3: On a clock edge with `phase`=0, `new_instr`=0 and `mpc_sel`=1, `ucode_addr` takes the value of `mpc`, and that word is read.
- R4: On a clock edge with `phase`=0 and both `new_instr` and `mpc_sel` high, `err` is set. The read still uses `func`.
- R5: Once set, `err` stays high until reset, whatever the inputs do.
- R6: Requests made on a clock edge with `phase`=1 are ignored. They change neither `ucode_addr` nor `err`, and they cause no dispatch.
- R7: A word read at a phase-0 edge appears on the field outputs at the next edge with `phase`=1. It is held unchanged across edges with `phase`=0.
- R8: Each valid flag is high exactly when its field is non-zero. A zero field is output as 0 with its valid flag low.
- R9: At an edge with `phase`=1 that has no pending read, every field is cleared to 0 and every valid flag goes low.
- R10: The field layout of a store word, with FW bits per field, is: PC at bits [FW-1:0], MPC at the next FW bits, memory next, register next, and ALU in the top FW bits.
- R11: With `ld_en`=1, the word `ld_data` is written to address `ld_addr` at the clock edge, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase | input | 1 | Current phase: 0 for read, 1 for dispatch |
| new_instr | input | 1 | A new instruction arrived this cycle |
| func | input | AW | Function field of the new instruction |
| mpc_sel | input | 1 | Microprogram counter addresses the store this cycle |
| mpc | input | AW | Microprogram counter value |
| ld_en | input | 1 | Store write enable |
| ld_addr | input | AW | Store write address |
| ld_data | input | 5*FW | Store write data |
| ucode_addr | output | AW | Address of the last word read |
| pc_fld | output | FW | Program counter field |
| pc_vld | output | 1 | Program counter field is non-zero |
| mpc_fld | output | FW | Microprogram counter field |
| mpc_vld | output | 1 | Microprogram counter field is non-zero |
| mem_fld | output | FW | Data memory field |
| mem_vld | output | 1 | Data memory field is non-zero |
| reg_fld | output | FW | Register file field |
| reg_vld | output | 1 | Register file field is non-zero |
| alu_fld | output | FW | ALU field |
| alu_vld | output | 1 | ALU field is non-zero |
| err | output | 1 | Sticky address-conflict flag |

## Verification
The assertions check on every cycle that:
- the address follows `func` or `mpc` with the right priority;
- a conflict sets `err`, and `err` never falls;
- the address does not move on phase-1 edges, and the outputs do not move on phase-0 edges;
- each valid flag agrees with its field;
- back-to-back phase-1 edges leave the outputs empty.

Only the bench's scenarios can show that the dispatched data is the correct word, with each field at its bit position, for every one of the 256 addresses reached through both paths. The same holds for requests during phase 1 producing no dispatch, for a rewritten word being read back, and for reset clearing a set error flag.

// File: rtl/ucode_dispatch.sv
module ucode_dispatch #(
  parameter int AW = 8,
  parameter int FW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase,
  input  logic              new_instr,
  input  logic [AW-1:0]     func,
  input  logic              mpc_sel,
  input  logic [AW-1:0]     mpc,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic [5*FW-1:0]   ld_data,
  output logic [AW-1:0]     ucode_addr,
  output logic [FW-1:0]     pc_fld,
  output logic              pc_vld,
  output logic [FW-1:0]     mpc_fld,
  output logic              mpc_vld,
  output logic [FW-1:0]     mem_fld,
  output logic              mem_vld,
  output logic [FW-1:0]     reg_fld,
  output logic              reg_vld,
  output logic [FW-1:0]     alu_fld,
  output logic              alu_vld,
  output logic              err
);
  localparam int NF    = 5;
  localparam int WW    = NF * FW;
  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] store [DEPTH];
  logic [WW-1:0] word_q;
  logic [AW-1:0] addr_q;
  logic          pend_q;
  logic          err_q;
  logic [FW-1:0] fld_q [NF];
  logic [NF-1:0] vld_q;

  wire           rd_req   = !phase && (new_instr || mpc_sel);
  wire           clash    = !phase && new_instr && mpc_sel;
  wire [AW-1:0]  sel_addr = new_instr ? func : mpc;

  always_ff @(posedge clk) begin
    if (ld_en) store[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (rd_req) begin
        addr_q <= sel_addr;
        word_q <= store[sel_addr];
      end
      pend_q <= rd_req;
      if (clash) err_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < NF; k++) begin : g_fld
    wire [FW-1:0] slice = word_q[k*FW +: FW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[k] <= '0;
        vld_q[k] <= 1'b0;
      end else if (phase) begin
        fld_q[k] <= pend_q ? slice : '0;
        vld_q[k] <= pend_q && (slice != '0);
      end
    end
  end

  assign ucode_addr = addr_q;
  assign err        = err_q;
  assign pc_fld     = fld_q[0];
  assign mpc_fld    = fld_q[1];
  assign mem_fld    = fld_q[2];
  assign reg_fld    = fld_q[3];
  assign alu_fld    = fld_q[4];
  assign pc_vld     = vld_q[0];
  assign mpc_vld    = vld_q[1];
  assign mem_vld    = vld_q[2];
  assign reg_vld    = vld_q[3];
  assign alu_vld    = vld_q[4];
endmodule

// File: rtl/ucode_dispatch_chk.sv
module ucode_dispatch_chk #(
  parameter int AW = 8,
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phase,
  input logic          new_instr,
  input logic [AW-1:0] func,
  input logic          mpc_sel,
  input logic [AW-1:0] mpc,
  input logic [AW-1:0] ucode_addr,
  input logic [FW-1:0] pc_fld,
  input logic          pc_vld,
  input logic [FW-1:0] mpc_fld,
  input logic          mpc_vld,
  input logic [FW-1:0] mem_fld,
  input logic          mem_vld,
  input logic [FW-1:0] reg_fld,
  input logic          reg_vld,
  input logic [FW-1:0] alu_fld,
  input logic          alu_vld,
  input logic          err
);
  wire [4:0] vlds = {alu_vld, reg_vld, mem_vld, mpc_vld, pc_vld};

  a_r2_addr_from_func: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && new_instr) |=> ucode_addr == $past(func));

  a_r3_addr_from_mpc: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && !new_instr && mpc_sel) |=> ucode_addr == $past(mpc));

  a_r4_conflict_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase && new_instr && mpc_sel) |=> err);

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  a_r6_addr_held_ph1: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> $stable(ucode_addr));

  a_r7_out_held_ph0: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> ($stable(vlds) && $stable(pc_fld) && $stable(mpc_fld)
                && $stable(mem_fld) && $stable(reg_fld) && $stable(alu_fld)));

  a_r8_valid_matches_field: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((pc_vld == (pc_fld != '0)) && (mpc_vld == (mpc_fld != '0))
           && (mem_vld == (mem_fld != '0)) && (reg_vld == (reg_fld != '0))
           && (alu_vld == (alu_fld != '0))));

  a_r9_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && $past(phase)) |=> (vlds == '0));
endmodule

bind ucode_dispatch ucode_dispatch_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .new_instr(new_instr), .func(func),
  .mpc_sel(mpc_sel), .mpc(mpc), .ucode_addr(ucode_addr),
  .pc_fld(pc_fld), .pc_vld(pc_vld), .mpc_fld(mpc_fld), .mpc_vld(mpc_vld),
  .mem_fld(mem_fld), .mem_vld(mem_vld), .reg_fld(reg_fld), .reg_vld(reg_vld),
  .alu_fld(alu_fld), .alu_vld(alu_vld), .err(err)
);

// File: tb/ucode_dispatch_bench.sv
module ucode_dispatch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int FW = 8;
  localparam int N  = 1 << AW;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            phase = 0, new_instr = 0, mpc_sel = 0, ld_en = 0;
  logic [AW-1:0]   func = 0, mpc = 0, ld_addr = 0;
  logic [5*FW-1:0] ld_data = 0;
  logic [AW-1:0]   ucode_addr;
  logic [FW-1:0]   pc_fld, mpc_fld, mem_fld, reg_fld, alu_fld;
  logic            pc_vld, mpc_vld, mem_vld, reg_vld, alu_vld, err;

  int checks = 0, errors = 0;

  ucode_dispatch #(.AW(AW), .FW(FW)) u_ucode_dispatch (
    .clk(clk), .rst_n(rst_n), .phase(phase), .new_instr(new_instr), .func(func),
    .mpc_sel(mpc_sel), .mpc(mpc), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .ucode_addr(ucode_addr), .pc_fld(pc_fld), .pc_vld(pc_vld), .mpc_fld(mpc_fld),
    .mpc_vld(mpc_vld), .mem_fld(mem_fld), .mem_vld(mem_vld), .reg_fld(reg_fld),
    .reg_vld(reg_vld), .alu_fld(alu_fld), .alu_vld(alu_vld), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] fexp(int a, int k);
    if ((a + k) % 5 == 0) return '0;
    return FW'((a * (2*k + 3) + 29*k + 1) & 8'hFF);
  endfunction

  function automatic logic [5*FW-1:0] wexp(int a);
    logic [5*FW-1:0] w;
    for (int k = 0; k < 5; k++) w[k*FW +: FW] = fexp(a, k);
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ph, input logic ni, input logic ms,
                      input logic [AW-1:0] f, input logic [AW-1:0] m);
    phase = ph; new_instr = ni; mpc_sel = ms; func = f; mpc = m;
    @(posedge clk); #1;
    new_instr = 0; mpc_sel = 0;
  endtask

  task automatic check_out(input string req, input logic [5*FW-1:0] w);
    logic [5*FW-1:0] got;
    logic [4:0] vexp;
    got  = {alu_fld, reg_fld, mem_fld, mpc_fld, pc_fld};
    for (int k = 0; k < 5; k++) vexp[k] = (w[k*FW +: FW] != '0);
    check(req, 64'(got), 64'(w));
    check({req, "/R8"}, 64'({alu_vld, reg_vld, mem_vld, mpc_vld, pc_vld}), 64'(vexp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check("R1", 64'({ucode_addr, err}), 64'(0));
    check_out("R1", '0);
    rst_n = 1;
    #(CLK_PERIOD);

    // R11 fill the store
    for (int a = 0; a < N; a++) begin
      ld_en = 1; ld_addr = AW'(a); ld_data = wexp(a);
      @(posedge clk); #1;
    end
    ld_en = 0;

    // R2 R10 sweep via function field
    for (int a = 0; a < N; a++) begin
      step(0, 1, 0, AW'(a), AW'(N - 1 - a));
      check("R2", 64'(ucode_addr), 64'(a));
      step(1, 0, 0, 0, 0);
      check_out("R2/R10", wexp(a));
    end

    // R3 sweep via microprogram counter
    for (int a = 0; a < N; a++) begin
      step(0, 0, 1, AW'(a ^ 8'h5A), AW'(a));
      check("R3", 64'(ucode_addr), 64'(a));
      step(1, 0, 0, 0, 0);
      check_out("R3", wexp(a));
    end

    // R7 hold across an idle phase 0, then R9 clear
    step(0, 1, 0, 8'd13, 0);
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check_out("R7", wexp(13));
    check("R7", 64'(ucode_addr), 64'(13));
    step(1, 0, 0, 0, 0);
    check_out("R9", '0);

    // R6 requests in phase 1 are ignored, including a conflict
    step(1, 1, 1, 8'd77, 8'd88);
    check("R6", 64'(ucode_addr), 64'(13));
    check("R6", 64'(err), 64'(0));
    check_out("R6", '0);
    step(1, 0, 0, 0, 0);
    check_out("R6", '0);

    // R11 overwrite one word and read it back
    ld_en = 1; ld_addr = 8'd7; ld_data = 40'hA5_00_3C_00_81;
    @(posedge clk); #1;
    ld_en = 0;
    step(0, 0, 1, 0, 8'd7);
    step(1, 0, 0, 0, 0);
    check_out("R11", 40'hA5_00_3C_00_81);

    // R4 conflict: flag set, function field wins
    step(0, 1, 1, 8'd40, 8'd200);
    check("R4", 64'(err), 64'(1));
    check("R4", 64'(ucode_addr), 64'(40));
    step(1, 0, 0, 0, 0);
    check_out("R4", wexp(40));

    // R5 flag stays set through normal traffic
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 1, 0, AW'(i * 9));
      step(1, 0, 0, 0, 0);
      check("R5", 64'(err), 64'(1));
    end
    rst_n = 0; #(CLK_PERIOD);
    check("R5/R1", 64'({ucode_addr, err}), 64'(0));
    check_out("R1", '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule